// File: doc/BRIEF.md
# Store-to-Load Forwarding Search Unit

This block takes a load that is ready to execute and decides, in a single cycle, where its data comes from. It searches the store queue entries that are older than the load, starting with the youngest of them. If an intersecting store holds every byte the load needs, its data is aligned and returned. If the store holds only some of those bytes, the load is sent back for replay and a stall is recorded. If no store intersects the load, the load goes to the data cache.

The store queue storage sits outside this block and presents its fields as flat vectors, together with the writeback pointer. The load side supplies the address, the size in bytes, the store-queue position captured when the load was inserted, the load-queue index, the sequence number, and two attributes: uncacheable, and at queue head and at commit. The decision is registered and appears one cycle after the request. The block keeps a single stall record, which always names the oldest load that hit a partial overlap, until the store side releases it.

Top module: `sfw_search`

## Requirements
- R1: One cycle after a cycle with `ld_valid` high, `res_valid` is high and exactly one of `res_fwd`, `res_part`, `res_mem` and `res_resched` is high. When `res_valid` is low, all four flags are low.
- R2: The entries searched run from index `ld_sq_idx-1` down to and including index `wb_ptr`, wrapping modulo `DEPTH`. When `ld_sq_idx` equals `wb_ptr`, no entry is searched.
- R3: Entries with `sq_valid` low, with a size of zero, or with `sq_uncache` high are skipped, even when their byte range intersects the load.
- R4: The youngest searched entry whose byte range [addr, addr+size) intersects the load's range decides the outcome. Older entries are ignored.
- R5: When the deciding store contains the whole load (ld_addr >= st_addr and ld_addr+ld_size <= st_addr+st_size), `res_fwd` is set. `res_data` is then the store data shifted right by 8*(ld_addr AND (st_size-1)) bits, with bytes at and above `ld_size` forced to zero (byte 0 is bits 7:0).
- R6: When the deciding store intersects the load but does not contain it, `res_part` is set, `res_part_seq` carries that store's sequence number, and neither forwarding nor a cache access is signalled.
- R7: A partial outcome records a stall (`stall_active`, the store's sequence number, and `ld_lq_idx`). If a stall is already active, it is overwritten only when the new load's `ld_seq` is numerically smaller than the recorded load's. `stall_clr` releases the stall. A partial outcome in the same cycle as `stall_clr` records a new stall.
- R8: An uncacheable load that does not have `ld_at_head` set gives `res_resched`, and the stall record is left unchanged. An uncacheable load with `ld_at_head` set is searched like any other load.
- R9: When no searched entry intersects the load, `res_mem` is set.
- R10: After reset, every result flag is low and `stall_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request present this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes (1, 2, 4, 8) |
| ld_sq_idx | input | IDX_W | Store-queue position captured when the load was inserted |
| ld_lq_idx | input | LQ_IDX_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_uncache | input | 1 | Load targets uncacheable memory |
| ld_at_head | input | 1 | Load is at the load-queue head and at commit |
| sq_addr_flat | input | DEPTH*ADDR_W | Store addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| sq_size_flat | input | DEPTH*SIZE_W | Store sizes in bytes, 0 = data not yet written |
| sq_data_flat | input | DEPTH*DATA_BYTES*8 | Store data, byte 0 in the low bits |
| sq_seq_flat | input | DEPTH*SEQ_W | Store sequence numbers |
| sq_valid | input | DEPTH | Entry holds a store |
| sq_uncache | input | DEPTH | Store targets uncacheable memory |
| wb_ptr | input | IDX_W | Oldest store not yet written back |
| stall_clr | input | 1 | Release the recorded stall |
| res_valid | output | 1 | Result present |
| res_fwd | output | 1 | Full forward |
| res_data | output | DATA_BYTES*8 | Aligned forwarded data |
| res_part | output | 1 | Partial overlap, load must replay |
| res_part_seq | output | SEQ_W | Sequence number of the partially overlapping store |
| res_mem | output | 1 | Load goes to the cache |
| res_resched | output | 1 | Uncacheable load not at head, reschedule |
| stall_active | output | 1 | Stall record valid |
| stall_store_seq | output | SEQ_W | Store the stalled load waits for |
| stall_lq_idx | output | LQ_IDX_W | Load-queue index of the stalled load |

## Verification
Two cases are the hardest to set up. The first is a search window that wraps past index zero while an intersecting store sits just outside the window. The second is a partial overlap that arrives while a stall is already held. Both depend on a specific combination of pointers, sequence numbers and store contents, and random choices seldom produce them. Directed sequences therefore build them explicitly: a window from index 1 back to index 6, skipped entries in front of a covering store, and a chain of partial loads that are younger, then older, then released, with a concurrent clear. Random requests over a 32-byte address range then mix every outcome, wraparound and stall updates.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  typedef enum logic [1:0] {
    OUT_MEM     = 2'd0,
    OUT_FWD     = 2'd1,
    OUT_PART    = 2'd2,
    OUT_RESCHED = 2'd3
  } sfw_outcome_e;
endpackage

// File: rtl/sfw_overlap.sv
// Byte-range comparison of one store entry against the load.
module sfw_overlap #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SIZE_W-1:0] st_size,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  output logic              hit_any,
  output logic              hit_full
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] st_lo, st_hi, ld_lo, ld_hi;

  always_comb begin
    st_lo    = EW'(st_addr);
    ld_lo    = EW'(ld_addr);
    st_hi    = st_lo + EW'(st_size);
    ld_hi    = ld_lo + EW'(ld_size);
    hit_any  = (ld_lo < st_hi) && (ld_hi > st_lo);
    hit_full = (ld_lo >= st_lo) && (ld_hi <= st_hi);
  end
endmodule

// File: rtl/sfw_age_pick.sv
// Selects the youngest candidate inside the window that starts at start_idx
// and runs win_len entries toward older positions.
module sfw_age_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] win_len,
  output logic             found,
  output logic [IDX_W-1:0] pick_idx
);
  logic [DEPTH-1:0] by_age;

  for (genvar gd = 0; gd < DEPTH; gd++) begin : g_rot
    assign by_age[gd] = cand[start_idx - IDX_W'(gd)] && (IDX_W'(gd) < win_len);
  end

  always_comb begin
    found    = 1'b0;
    pick_idx = start_idx;
    for (int d = 0; d < DEPTH; d++) begin
      if (!found && by_age[d]) begin
        found    = 1'b1;
        pick_idx = start_idx - IDX_W'(d);
      end
    end
  end
endmodule

// File: rtl/sfw_align.sv
// Shifts store data to the load's byte offset and clears bytes beyond its size.
module sfw_align #(
  parameter int DATA_BYTES = 8,
  parameter int SIZE_W     = 4,
  localparam int OFF_W     = $clog2(DATA_BYTES),
  localparam int DATA_W    = DATA_BYTES * 8
) (
  input  logic [DATA_W-1:0] st_data,
  input  logic [SIZE_W-1:0] st_size,
  input  logic [OFF_W-1:0]  ld_addr_lo,
  input  logic [SIZE_W-1:0] ld_size,
  output logic [DATA_W-1:0] out_data
);
  logic [OFF_W-1:0]  byte_off;
  logic [DATA_W-1:0] shifted;

  assign byte_off = ld_addr_lo & OFF_W'(st_size - SIZE_W'(1));
  assign shifted  = st_data >> {byte_off, 3'b000};

  for (genvar gb = 0; gb < DATA_BYTES; gb++) begin : g_byte
    assign out_data[gb*8 +: 8] = (SIZE_W'(gb) < ld_size) ? shifted[gb*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sfw_search.sv
module sfw_search
  import sfw_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 4,
  parameter int DATA_BYTES = 8,
  parameter int SEQ_W      = 12,
  parameter int LQ_IDX_W   = 4,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int OFF_W     = $clog2(DATA_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [SIZE_W-1:0]         ld_size,
  input  logic [IDX_W-1:0]          ld_sq_idx,
  input  logic [LQ_IDX_W-1:0]       ld_lq_idx,
  input  logic [SEQ_W-1:0]          ld_seq,
  input  logic                      ld_uncache,
  input  logic                      ld_at_head,
  input  logic [DEPTH*ADDR_W-1:0]   sq_addr_flat,
  input  logic [DEPTH*SIZE_W-1:0]   sq_size_flat,
  input  logic [DEPTH*DATA_W-1:0]   sq_data_flat,
  input  logic [DEPTH*SEQ_W-1:0]    sq_seq_flat,
  input  logic [DEPTH-1:0]          sq_valid,
  input  logic [DEPTH-1:0]          sq_uncache,
  input  logic [IDX_W-1:0]          wb_ptr,
  input  logic                      stall_clr,
  output logic                      res_valid,
  output logic                      res_fwd,
  output logic [DATA_W-1:0]         res_data,
  output logic                      res_part,
  output logic [SEQ_W-1:0]          res_part_seq,
  output logic                      res_mem,
  output logic                      res_resched,
  output logic                      stall_active,
  output logic [SEQ_W-1:0]          stall_store_seq,
  output logic [LQ_IDX_W-1:0]       stall_lq_idx
);

  // ---------------- per-entry comparison ----------------
  logic [SIZE_W-1:0] sq_size_a [DEPTH];
  logic [DATA_W-1:0] sq_data_a [DEPTH];
  logic [SEQ_W-1:0]  sq_seq_a  [DEPTH];
  logic [DEPTH-1:0]  hit_any_v, hit_full_v, cand_v;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    assign sq_size_a[gi] = sq_size_flat[gi*SIZE_W +: SIZE_W];
    assign sq_data_a[gi] = sq_data_flat[gi*DATA_W +: DATA_W];
    assign sq_seq_a[gi]  = sq_seq_flat[gi*SEQ_W +: SEQ_W];

    sfw_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
      .st_addr  (sq_addr_flat[gi*ADDR_W +: ADDR_W]),
      .st_size  (sq_size_a[gi]),
      .ld_addr  (ld_addr),
      .ld_size  (ld_size),
      .hit_any  (hit_any_v[gi]),
      .hit_full (hit_full_v[gi])
    );

    assign cand_v[gi] = sq_valid[gi] && !sq_uncache[gi] &&
                        (sq_size_a[gi] != '0) && hit_any_v[gi];
  end

  // ---------------- age-ordered select ----------------
  logic [IDX_W-1:0] scan_start, scan_len, pick_idx;
  logic             pick_found;

  assign scan_start = ld_sq_idx - IDX_W'(1);
  assign scan_len   = ld_sq_idx - wb_ptr;

  sfw_age_pick #(.DEPTH(DEPTH)) u_pick (
    .cand      (cand_v),
    .start_idx (scan_start),
    .win_len   (scan_len),
    .found     (pick_found),
    .pick_idx  (pick_idx)
  );

  // ---------------- data alignment ----------------
  logic [DATA_W-1:0] fwd_data_d;

  sfw_align #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_align (
    .st_data    (sq_data_a[pick_idx]),
    .st_size    (sq_size_a[pick_idx]),
    .ld_addr_lo (ld_addr[OFF_W-1:0]),
    .ld_size    (ld_size),
    .out_data   (fwd_data_d)
  );

  // ---------------- outcome decision ----------------
  sfw_outcome_e outc;

  always_comb begin
    if (ld_uncache && !ld_at_head)      outc = OUT_RESCHED;
    else if (!pick_found)               outc = OUT_MEM;
    else if (hit_full_v[pick_idx])      outc = OUT_FWD;
    else                                outc = OUT_PART;
  end

  // ---------------- result registers ----------------
  logic res_valid_d, res_fwd_d, res_part_d, res_mem_d, res_resched_d;
  logic data_en, pseq_en;

  always_comb begin
    res_valid_d   = ld_valid;
    res_fwd_d     = ld_valid && (outc == OUT_FWD);
    res_part_d    = ld_valid && (outc == OUT_PART);
    res_mem_d     = ld_valid && (outc == OUT_MEM);
    res_resched_d = ld_valid && (outc == OUT_RESCHED);
    data_en       = res_fwd_d;
    pseq_en       = res_part_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_fwd     <= 1'b0;
      res_part    <= 1'b0;
      res_mem     <= 1'b0;
      res_resched <= 1'b0;
    end else begin
      res_valid   <= res_valid_d;
      res_fwd     <= res_fwd_d;
      res_part    <= res_part_d;
      res_mem     <= res_mem_d;
      res_resched <= res_resched_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data <= '0;
    end else if (data_en) begin
      res_data <= fwd_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_part_seq <= '0;
    end else if (pseq_en) begin
      res_part_seq <= sq_seq_a[pick_idx];
    end
  end

  // ---------------- stall record ----------------
  logic [SEQ_W-1:0]    stall_ld_seq_q;
  logic                stall_held, stall_take, stall_en;
  logic                stall_active_d;
  logic [SEQ_W-1:0]    stall_store_seq_d, stall_ld_seq_d;
  logic [LQ_IDX_W-1:0] stall_lq_idx_d;

  always_comb begin
    stall_held        = stall_active && !stall_clr;
    stall_take        = res_part_d && (!stall_held || (ld_seq < stall_ld_seq_q));
    stall_en          = stall_take || stall_clr;
    stall_active_d    = stall_take;
    stall_store_seq_d = stall_store_seq;
    stall_ld_seq_d    = stall_ld_seq_q;
    stall_lq_idx_d    = stall_lq_idx;
    if (stall_take) begin
      stall_store_seq_d = sq_seq_a[pick_idx];
      stall_ld_seq_d    = ld_seq;
      stall_lq_idx_d    = ld_lq_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_active    <= 1'b0;
      stall_store_seq <= '0;
      stall_ld_seq_q  <= '0;
      stall_lq_idx    <= '0;
    end else if (stall_en) begin
      stall_active    <= stall_active_d;
      stall_store_seq <= stall_store_seq_d;
      stall_ld_seq_q  <= stall_ld_seq_d;
      stall_lq_idx    <= stall_lq_idx_d;
    end
  end

endmodule

// File: rtl/sfw_search_chk.sv
module sfw_search_chk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_uncache,
  input logic             ld_at_head,
  input logic [IDX_W-1:0] ld_sq_idx,
  input logic [IDX_W-1:0] wb_ptr,
  input logic             stall_clr,
  input logic             res_valid,
  input logic             res_fwd,
  input logic             res_part,
  input logic             res_mem,
  input logic             res_resched,
  input logic             stall_active,
  input logic [SEQ_W-1:0] stall_ld_seq
);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_fwd, res_part, res_mem, res_resched}) == 1));

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_fwd || res_part || res_mem || res_resched));

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);

  p_empty_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && (ld_sq_idx == wb_ptr) && !(ld_uncache && !ld_at_head)) |=> res_mem);

  p_part_records_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_part |-> stall_active);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && !stall_clr) |=> stall_active);

  p_stall_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && !stall_clr) |=> (stall_ld_seq <= $past(stall_ld_seq)));

  p_resched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_uncache && !ld_at_head) |=> res_resched);
endmodule

bind sfw_search sfw_search_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_valid     (ld_valid),
  .ld_uncache   (ld_uncache),
  .ld_at_head   (ld_at_head),
  .ld_sq_idx    (ld_sq_idx),
  .wb_ptr       (wb_ptr),
  .stall_clr    (stall_clr),
  .res_valid    (res_valid),
  .res_fwd      (res_fwd),
  .res_part     (res_part),
  .res_mem      (res_mem),
  .res_resched  (res_resched),
  .stall_active (stall_active),
  .stall_ld_seq (stall_ld_seq_q)
);

// File: tb/sfw_search_bench.sv
`timescale 1ns/1ps
module sfw_search_bench;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ld_valid = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [3:0]  ld_size = 4'd1;
  logic [2:0]  ld_sq_idx = '0;
  logic [3:0]  ld_lq_idx = '0;
  logic [11:0] ld_seq = '0;
  logic        ld_uncache = 1'b0;
  logic        ld_at_head = 1'b0;
  logic [2:0]  wb_ptr = '0;
  logic        stall_clr = 1'b0;

  logic [15:0] s_addr [D];
  logic [3:0]  s_size [D];
  logic [63:0] s_data [D];
  logic [11:0] s_seq  [D];
  logic [D-1:0] s_val, s_unc;

  logic [D*16-1:0] sq_addr_flat;
  logic [D*4-1:0]  sq_size_flat;
  logic [D*64-1:0] sq_data_flat;
  logic [D*12-1:0] sq_seq_flat;

  always_comb begin
    for (int i = 0; i < D; i++) begin
      sq_addr_flat[i*16 +: 16] = s_addr[i];
      sq_size_flat[i*4 +: 4]   = s_size[i];
      sq_data_flat[i*64 +: 64] = s_data[i];
      sq_seq_flat[i*12 +: 12]  = s_seq[i];
    end
  end

  logic        res_valid, res_fwd, res_part, res_mem, res_resched, stall_active;
  logic [63:0] res_data;
  logic [11:0] res_part_seq, stall_store_seq;
  logic [3:0]  stall_lq_idx;

  sfw_search u_sfw_search (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_sq_idx(ld_sq_idx), .ld_lq_idx(ld_lq_idx), .ld_seq(ld_seq), .ld_uncache(ld_uncache),
    .ld_at_head(ld_at_head), .sq_addr_flat(sq_addr_flat), .sq_size_flat(sq_size_flat),
    .sq_data_flat(sq_data_flat), .sq_seq_flat(sq_seq_flat), .sq_valid(s_val),
    .sq_uncache(s_unc), .wb_ptr(wb_ptr), .stall_clr(stall_clr), .res_valid(res_valid),
    .res_fwd(res_fwd), .res_data(res_data), .res_part(res_part), .res_part_seq(res_part_seq),
    .res_mem(res_mem), .res_resched(res_resched), .stall_active(stall_active),
    .stall_store_seq(stall_store_seq), .stall_lq_idx(stall_lq_idx)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference stall record
  logic        m_act = 1'b0;
  logic [11:0] m_sseq = '0, m_lseq = '0;
  logic [3:0]  m_lq = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_sq();
    for (int i = 0; i < D; i++) begin
      s_addr[i] = '0; s_size[i] = '0; s_data[i] = '0; s_seq[i] = '0;
    end
    s_val = '0; s_unc = '0;
  endtask

  task automatic put(int i, int a, int sz, logic [63:0] dat, int sq, bit unc);
    s_addr[i] = 16'(a); s_size[i] = 4'(sz); s_data[i] = dat; s_seq[i] = 12'(sq);
    s_val[i] = 1'b1; s_unc[i] = unc;
  endtask

  // tag "" means: pick the tag from the expected outcome
  task automatic req(string tag, int a, int sz, int sqi, int wb, bit unc, bit head,
                     int seq, int lq, bit clr);
    logic [3:0]  ef;   // {fwd, part, mem, resched}
    logic [63:0] edata;
    logic [11:0] epseq;
    int n, se, le, off;
    bit done;
    string t;
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 16'(a); ld_size = 4'(sz); ld_sq_idx = 3'(sqi);
    wb_ptr = 3'(wb); ld_uncache = unc; ld_at_head = head; ld_seq = 12'(seq);
    ld_lq_idx = 4'(lq); stall_clr = clr;
    edata = '0; epseq = '0; done = 0;
    if (unc && !head) begin
      ef = 4'b0001;
    end else begin
      ef = 4'b0010;
      n = (sqi - wb) & (D - 1);
      for (int d = 0; d < D; d++) begin
        int i;
        i = (sqi - 1 - d) & (D - 1);
        if (!done && d < n && s_val[i] && !s_unc[i] && s_size[i] != 0) begin
          se = int'(s_addr[i]) + int'(s_size[i]);
          le = a + sz;
          if (a < se && le > int'(s_addr[i])) begin
            done = 1;
            if (a >= int'(s_addr[i]) && le <= se) begin
              ef = 4'b1000;
              off = a & (int'(s_size[i]) - 1);
              edata = s_data[i] >> (8 * off);
              if (sz < 8) edata = edata & ((64'h1 << (8 * sz)) - 64'h1);
            end else begin
              ef = 4'b0100;
              epseq = s_seq[i];
            end
          end
        end
      end
    end
    // stall reference
    if (ef == 4'b0100 && (!(m_act && !clr) || 12'(seq) < m_lseq)) begin
      m_act = 1'b1; m_sseq = epseq; m_lseq = 12'(seq); m_lq = 4'(lq);
    end else if (clr) begin
      m_act = 1'b0;
    end
    @(negedge clk);
    ld_valid = 1'b0; stall_clr = 1'b0;
    t = tag;
    if (t == "") t = ef[3] ? "R5" : ef[2] ? "R6" : ef[1] ? "R9" : "R8";
    chk("R1", "res_valid", 64'(res_valid), 64'h1);
    chk(t, "outcome{fwd,part,mem,resched}", 64'({res_fwd, res_part, res_mem, res_resched}), 64'(ef));
    if (ef[3]) chk("R5", "res_data", res_data, edata);
    if (ef[2]) chk("R6", "res_part_seq", 64'(res_part_seq), 64'(epseq));
    chk("R7", "stall_active", 64'(stall_active), 64'(m_act));
    if (m_act) begin
      chk("R7", "stall_store_seq", 64'(stall_store_seq), 64'(m_sseq));
      chk("R7", "stall_lq_idx", 64'(stall_lq_idx), 64'(m_lq));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    clear_sq();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "flags after reset",
        64'({res_valid, res_fwd, res_part, res_mem, res_resched, stall_active}), 64'h0);

    // R2: empty window, overlapping store present
    clear_sq();
    put(2, 'h10, 8, 64'h8877665544332211, 5, 0);
    req("R2", 'h10, 4, 3, 3, 0, 0, 100, 1, 0);
    // R2: window wraps 0,7,6; covering store at 6
    clear_sq();
    put(6, 'h10, 8, 64'h8877665544332211, 6, 0);
    put(5, 'h10, 1, 64'h00000000000000aa, 7, 0);
    req("R2", 'h13, 2, 1, 6, 0, 0, 101, 2, 0);
    // R2: store only outside window (index 5) gives memory
    s_val[6] = 1'b0;
    req("R2", 'h10, 1, 1, 6, 0, 0, 102, 2, 0);
    // R3: uncacheable and zero-size youngest entries skipped
    clear_sq();
    put(7, 'h20, 8, 64'h0102030405060708, 9, 0);
    put(0, 'h20, 8, 64'hffffffffffffffff, 10, 1);
    put(1, 'h20, 0, 64'heeeeeeeeeeeeeeee, 11, 0);
    req("R3", 'h24, 4, 2, 7, 0, 0, 103, 3, 0);
    // R4: youngest intersecting partial wins over older full
    clear_sq();
    put(3, 'h30, 8, 64'h1111111111111111, 20, 0);
    put(4, 'h34, 2, 64'h0000000000002222, 21, 0);
    req("R4", 'h30, 8, 5, 3, 0, 0, 200, 5, 0);
    // R7: younger partial does not overwrite, older does, clear releases
    req("R7", 'h30, 8, 5, 3, 0, 0, 300, 6, 0);
    req("R7", 'h30, 8, 5, 3, 0, 0, 150, 7, 0);
    req("R7", 'h40, 4, 5, 3, 0, 0, 151, 8, 1);
    // R7: partial concurrent with clear records fresh even if younger
    req("R7", 'h30, 8, 5, 3, 0, 0, 140, 9, 0);
    req("R7", 'h30, 8, 5, 3, 0, 0, 400, 10, 1);
    // R8: uncacheable not at head reschedules, stall unchanged
    req("R8", 'h30, 8, 5, 3, 1, 0, 10, 11, 0);
    // R8: uncacheable at head is searched
    req("R8", 'h34, 2, 5, 3, 1, 1, 11, 12, 0);
    req("R9", 'h50, 4, 5, 3, 1, 1, 12, 13, 1);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int sz, a, sqi, wb;
      for (int i = 0; i < D; i++) begin
        int ss;
        ss = ($urandom % 5 == 0) ? 0 : (1 << ($urandom % 4));
        put(i, (ss == 0) ? int'($urandom % 32) : (int'($urandom % 32) & ~(ss - 1)),
            ss, {$urandom, $urandom}, int'($urandom % 4096), ($urandom % 8) == 0);
        s_val[i] = ($urandom % 8) != 0;
      end
      sz  = 1 << ($urandom % 4);
      a   = int'($urandom % 32) & ~(sz - 1);
      sqi = int'($urandom % D);
      wb  = int'($urandom % D);
      req("", a, sz, sqi, wb, ($urandom % 6) == 0, ($urandom % 2) == 0,
          int'($urandom % 4096), int'($urandom % 16), ($urandom % 8) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule